// File: doc/BRIEF.md
# NAND Flash Command Interface Front-End

This block is the device-side input stage of a NAND-style flash memory. It watches the write-enable and read-enable pins through clock-domain synchronizers and acts on their edges. At each write-enable rising edge it sorts the word on the I/O bus into one of three kinds: a command, an address cycle or page data. The command-latch and address-latch strobes, sampled at that edge, decide which kind it is.

Address cycles fill a column field first and a row field after it, one byte per cycle, starting with the lowest byte. Plain data words go into a small behavioural page buffer at the current column. Each read-enable falling edge presents the buffer word at the current column on the output bus. Both a data write and a read advance the column by one.

Chip enable is active low. While the core reports busy, raising chip enable does not put the block into standby, and the block keeps responding to the strobes.

Top module: `nand_cmd_front`

## Requirements
- R1: Each write-enable rising edge (pin `we_ni` going 0 to 1) is acted on exactly once, however long the pin then stays high. The effect shows at the outputs within five clock cycles of the edge.
- R2: When `cle_i`=1 and `ale_i`=0 at a write edge, `io_i[7:0]` is stored in `cmd_o` and `cmd_valid_o` pulses for one cycle. Bits 15:8 of the bus are not used. `cmd_o` changes at no other time.
- R3: When `ale_i`=1 and `cle_i`=0 at a write edge, the byte is an address cycle. Cycles 0 and 1 load `col_o[7:0]` and then `col_o[15:8]`. Cycles 2, 3 and 4 load `row_o[7:0]`, then `row_o[15:8]`, then `row_o[23:16]`. A command cycle restarts this count at cycle 0.
- R4: Address cycles beyond the fifth since the last command change neither `col_o` nor `row_o`.
- R5: When `cle_i`=0 and `ale_i`=0 at a write edge, the bus word is written to the page buffer at the current column. `col_o` then increases by one.
- R6: Each read-enable falling edge loads `io_o` with the page-buffer word at the current column. `col_o` then increases by one.
- R7: When `cle_i` and `ale_i` are both 1 at a write edge, `illegal_o` pulses for one cycle. `cmd_o`, `col_o` and `row_o` stay unchanged and no command is reported.
- R8: When `ce_ni`=1 and `busy_i`=0, `standby_o` is 1, `io_oe_o` is 0, and write and read edges have no effect.
- R9: When `ce_ni`=1 and `busy_i`=1, `standby_o` is 0 and write edges are still acted on.
- R10: `io_oe_o` is 1 exactly when the block is not in standby and the synchronized read-enable level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| busy_i | input | 1 | Core busy indication |
| cle_i | input | 1 | Command latch strobe |
| ale_i | input | 1 | Address latch strobe |
| we_ni | input | 1 | Write enable pin, asynchronous, active low |
| re_ni | input | 1 | Read enable pin, asynchronous, active low |
| io_i | input | DATA_W | Bus input value |
| io_o | output | DATA_W | Bus output value |
| io_oe_o | output | 1 | Bus output enable (0 means tri-stated) |
| cmd_o | output | 8 | Last command byte |
| cmd_valid_o | output | 1 | One-cycle pulse when a command is stored |
| col_o | output | 8*COL_BYTES | Column address counter |
| row_o | output | 8*ROW_BYTES | Row address |
| illegal_o | output | 1 | One-cycle pulse on a cycle with both strobes high |
| standby_o | output | 1 | Deselected and idle |

## Verification
A wrong address-cycle count shows up as a byte landing in the wrong field of `col_o` or `row_o`. This is visible a few cycles after the next address edge, and the bench checks both fields after every address sequence. A column counter that is off by one, or that fails to advance, makes the next read return the wrong word on `io_o` at that read edge. It also leaves `col_o` wrong right away. An edge detector that fires twice, or a strobe decode that is wrong, produces an extra or missing `cmd_valid_o` or `illegal_o` pulse. The event scoreboard catches such a pulse in the cycle it appears.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_CMD   = 2'd1,
    KIND_ADDR  = 2'd2,
    KIND_CLASH = 2'd3
  } byte_kind_e;

  function automatic byte_kind_e classify(input logic cle, input logic ale);
    case ({cle, ale})
      2'b10:   return KIND_CMD;
      2'b01:   return KIND_ADDR;
      2'b11:   return KIND_CLASH;
      default: return KIND_DATA;
    endcase
  endfunction
endpackage

// File: rtl/nand_fe_edge_sync.sv
module nand_fe_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= pin_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b1;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
  assign fall_o  = ~chain_q[STAGES-1] & last_q;

  p_rise_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/nand_fe_addr_reg.sv
module nand_fe_addr_reg #(
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3,
  localparam int COL_W = 8 * COL_BYTES,
  localparam int ROW_W = 8 * ROW_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_hit_i,
  input  logic             addr_hit_i,
  input  logic [7:0]       addr_byte_i,
  input  logic             col_inc_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TOTAL = COL_BYTES + ROW_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TOTAL);

  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cmd_hit_i) begin
      cnt_q <= '0;
    end else if (addr_hit_i && cnt_q != CNT_END) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (addr_hit_i) begin
      for (int k = 0; k < COL_BYTES; k++)
        if (cnt_q == CNT_W'(k)) col_q[8*k +: 8] <= addr_byte_i;
    end else if (col_inc_i) begin
      col_q <= col_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
    end else if (addr_hit_i) begin
      for (int k = 0; k < ROW_BYTES; k++)
        if (cnt_q == CNT_W'(COL_BYTES + k)) row_q[8*k +: 8] <= addr_byte_i;
    end
  end

  assign col_o = col_q;
  assign row_o = row_q;

  p_cnt_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit_i |=> cnt_q == '0);
  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_END);
  p_addr_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hit_i && cnt_q == CNT_END) |=> ($stable(col_q) && $stable(row_q)));
  p_col_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_inc_i && !addr_hit_i) |=> col_q == $past(col_q) + 1'b1);
endmodule

// File: rtl/nand_fe_page_buf.sv
module nand_fe_page_buf #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int COL_BYTES   = 2,
  parameter int ROW_BYTES   = 3,
  parameter int PAGE_DEPTH  = 64,
  parameter int SYNC_STAGES = 2,
  localparam int COL_W = 8 * COL_BYTES,
  localparam int ROW_W = 8 * ROW_BYTES,
  localparam int IDX_W = $clog2(PAGE_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              busy_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic              we_ni,
  input  logic              re_ni,
  input  logic [DATA_W-1:0] io_i,
  output logic [DATA_W-1:0] io_o,
  output logic              io_oe_o,
  output logic [7:0]        cmd_o,
  output logic              cmd_valid_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              illegal_o,
  output logic              standby_o
);
  logic we_lvl, we_rise, we_fall;
  logic re_lvl, re_rise, re_fall;
  logic selected;
  byte_kind_e kind;
  logic wr_act, rd_act;
  logic cmd_hit, addr_hit, data_hit, clash_hit;
  logic [7:0] cmd_q;
  logic cmd_valid_q, illegal_q;
  logic [DATA_W-1:0] dout_q, buf_rd;
  logic [COL_W-1:0] col;

  nand_fe_edge_sync #(.STAGES(SYNC_STAGES)) u_we_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(we_ni),
    .level_o(we_lvl), .rise_o(we_rise), .fall_o(we_fall)
  );

  nand_fe_edge_sync #(.STAGES(SYNC_STAGES)) u_re_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(re_ni),
    .level_o(re_lvl), .rise_o(re_rise), .fall_o(re_fall)
  );

  // Busy keeps the device selected even with chip enable released
  assign standby_o = ce_ni & ~busy_i;
  assign selected  = ~standby_o;

  assign kind      = classify(cle_i, ale_i);
  assign wr_act    = selected & we_rise;
  assign rd_act    = selected & re_fall & ~wr_act;
  assign cmd_hit   = wr_act & (kind == KIND_CMD);
  assign addr_hit  = wr_act & (kind == KIND_ADDR);
  assign data_hit  = wr_act & (kind == KIND_DATA);
  assign clash_hit = wr_act & (kind == KIND_CLASH);

  nand_fe_addr_reg #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_hit_i(cmd_hit), .addr_hit_i(addr_hit), .addr_byte_i(io_i[7:0]),
    .col_inc_i(data_hit | rd_act),
    .col_o(col), .row_o(row_o)
  );

  nand_fe_page_buf #(.DEPTH(PAGE_DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk_i(clk_i), .wr_en_i(data_hit), .wr_idx_i(col[IDX_W-1:0]),
    .wr_data_i(io_i), .rd_idx_i(col[IDX_W-1:0]), .rd_data_o(buf_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      cmd_valid_q <= 1'b0;
      illegal_q   <= 1'b0;
      dout_q      <= '0;
    end else begin
      cmd_valid_q <= cmd_hit;
      illegal_q   <= clash_hit;
      if (cmd_hit) cmd_q <= io_i[7:0];
      if (rd_act)  dout_q <= buf_rd;
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_valid_o = cmd_valid_q;
  assign illegal_o   = illegal_q;
  assign col_o       = col;
  assign io_o        = dout_q;
  assign io_oe_o     = selected & ~re_lvl;

  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> $stable(cmd_o));
  p_clash_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!cmd_valid_o && $stable(cmd_o) && $stable(col_o) && $stable(row_o)));
  p_standby_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !io_oe_o);
  p_oe_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> (!re_lvl && !standby_o));
  p_busy_select_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !standby_o);
endmodule

// File: tb/nand_cmd_front_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_front_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, busy = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [DW-1:0] io_in = '0;
  logic [DW-1:0] io_out;
  logic io_oe, cmd_valid, illegal, standby;
  logic [7:0] cmd;
  logic [15:0] col;
  logic [23:0] row;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { bit is_clash; logic [7:0] val; } ev_t;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;

  nand_cmd_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .busy_i(busy),
    .cle_i(cle), .ale_i(ale), .we_ni(we_n), .re_ni(re_n),
    .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .cmd_o(cmd), .cmd_valid_o(cmd_valid), .col_o(col), .row_o(row),
    .illegal_o(illegal), .standby_o(standby)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every event pulse pops one expected item
  always @(negedge clk) begin
    if (rst_n && (cmd_valid || illegal)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1/R2/R7 unexpected event", {illegal, cmd_valid, 22'd0, cmd}, 32'h0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.is_clash) chk(illegal && !cmd_valid, "R7 clash event", {30'd0, illegal, cmd_valid}, 32'h2);
        else chk(cmd_valid && !illegal && cmd == e.val, "R2 command event", {23'd0, cmd_valid, cmd}, {24'd1, e.val});
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic we_cycle(input logic c, input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    cle = c; ale = a; io_in = d; we_n = 1'b0;
    wclk(4);
    we_n = 1'b1;
    wclk(8);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic send_cmd(input logic [DW-1:0] d, input bit expect_ev);
    if (expect_ev) exp_q.push_back('{1'b0, d[7:0]});
    we_cycle(1'b1, 1'b0, d);
  endtask

  task automatic send_addr(input logic [7:0] b);
    we_cycle(1'b0, 1'b1, {8'hEE, b});
  endtask

  task automatic read_word(input logic [DW-1:0] exp_d, input logic [15:0] exp_col);
    @(negedge clk);
    re_n = 1'b0;
    wclk(6);
    chk(io_oe === 1'b1, "R10 oe during read", {31'd0, io_oe}, 32'd1);
    chk(io_out === exp_d, "R6 read data", {16'd0, io_out}, {16'd0, exp_d});
    chk(col === exp_col, "R6 column step on read", {16'd0, col}, {16'd0, exp_col});
    re_n = 1'b1;
    wclk(6);
    chk(io_oe === 1'b0, "R10 oe off after read", {31'd0, io_oe}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [DW-1:0] wdata [4];

  initial begin
    wdata[0] = 16'h1234; wdata[1] = 16'hBEEF; wdata[2] = 16'h00A5; wdata[3] = 16'h5A5A;
    wclk(4);
    rst_n = 1'b1;
    wclk(2);
    // reset state
    chk(standby === 1'b1, "R8 reset standby", {31'd0, standby}, 32'd1);
    chk(io_oe === 1'b0, "R8 reset oe", {31'd0, io_oe}, 32'd0);
    chk(cmd === 8'h00, "R2 reset cmd", {24'd0, cmd}, 32'd0);
    chk(col === 16'd0, "R5 reset col", {16'd0, col}, 32'd0);

    ce_n = 1'b0;
    wclk(2);
    chk(standby === 1'b0, "R8 selected", {31'd0, standby}, 32'd0);

    // R1, R2: upper bus bits ignored, single event per edge
    send_cmd(16'hAB80, 1'b1);
    chk(cmd === 8'h80, "R2 command low byte", {24'd0, cmd}, 32'h80);

    // R3: column then row
    send_addr(8'h02); send_addr(8'h00);
    send_addr(8'h11); send_addr(8'h22); send_addr(8'h33);
    chk(col === 16'h0002, "R3 column field", {16'd0, col}, 32'h2);
    chk(row === 24'h332211, "R3 row field", {8'd0, row}, 32'h332211);

    // R4: extra address byte ignored
    send_addr(8'h77);
    chk(col === 16'h0002, "R4 column kept", {16'd0, col}, 32'h2);
    chk(row === 24'h332211, "R4 row kept", {8'd0, row}, 32'h332211);

    // R5: data writes
    for (int i = 0; i < 4; i++) begin
      we_cycle(1'b0, 1'b0, wdata[i]);
      chk(col === 16'(3 + i), "R5 column step on write", {16'd0, col}, 32'(3 + i));
    end

    // R3: new command restarts address count
    send_cmd(16'h0000, 1'b1);
    send_addr(8'h02); send_addr(8'h00);
    send_addr(8'hA1); send_addr(8'hB2); send_addr(8'hC3);
    chk(col === 16'h0002, "R3 restart column", {16'd0, col}, 32'h2);
    chk(row === 24'hC3B2A1, "R3 restart row", {8'd0, row}, 32'hC3B2A1);

    // R6, R10: read back
    for (int i = 0; i < 4; i++) read_word(wdata[i], 16'(3 + i));

    // R7: both strobes
    exp_q.push_back('{1'b1, 8'h00});
    we_cycle(1'b1, 1'b1, 16'h0055);
    chk(cmd === 8'h00, "R7 cmd kept", {24'd0, cmd}, 32'h0);
    chk(col === 16'd6, "R7 col kept", {16'd0, col}, 32'd6);
    chk(row === 24'hC3B2A1, "R7 row kept", {8'd0, row}, 32'hC3B2A1);

    // R8: deselected and idle
    ce_n = 1'b1;
    wclk(2);
    chk(standby === 1'b1, "R8 standby", {31'd0, standby}, 32'd1);
    send_cmd(16'h0070, 1'b0);
    chk(cmd === 8'h00, "R8 cmd ignored", {24'd0, cmd}, 32'h0);
    we_cycle(1'b0, 1'b0, 16'hFFFF);
    chk(col === 16'd6, "R8 data ignored", {16'd0, col}, 32'd6);
    @(negedge clk); re_n = 1'b0;
    wclk(6);
    chk(io_oe === 1'b0, "R8 oe off when deselected", {31'd0, io_oe}, 32'd0);
    re_n = 1'b1;
    wclk(6);
    chk(col === 16'd6, "R8 read ignored", {16'd0, col}, 32'd6);

    // R9: busy keeps selection
    busy = 1'b1;
    wclk(2);
    chk(standby === 1'b0, "R9 no standby while busy", {31'd0, standby}, 32'd0);
    send_cmd(16'h0090, 1'b1);
    chk(cmd === 8'h90, "R9 cmd accepted while busy", {24'd0, cmd}, 32'h90);
    busy = 1'b0;
    ce_n = 1'b0;
    wclk(4);

    chk(exp_q.size() == 0, "R1 all events seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule